// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire serial converter link: chip select, serial clock and serial data. A single start request makes it run one full conversion frame. It lowers chip select and produces serial clock pulses from an even division of the system clock. It waits until the converter's sample window has closed, then takes the data bits on rising serial clock edges, most significant bit first. At the end of the frame it raises chip select again.

Chip select then stays high for a programmed number of system clocks. This enforces the recovery time the converter needs between conversions, and the high level also keeps the converter in its low-power state. After that interval the controller gives the assembled sample with a one-cycle valid strobe and drops its busy flag. A start request that arrives while a frame is in progress has no effect. Because chip select always returns high between frames, every conversion begins with a fresh falling edge of chip select.

Top module: `adc_frame_ctrl`

## Requirements
- R1: During reset and while idle, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `valid` is 0.
- R2: A `start` pulse sampled while idle drives `cs_n` to 0 and `busy` to 1 on the next clock edge.
- R3: Each high phase and each low phase of `sclk` while `cs_n` is low lasts exactly `HALF_CYC` system clocks. `sclk` is 0 whenever `cs_n` is 1.
- R4: A frame contains exactly `CAP_IDX + DATA_W - 1` `sclk` pulses. `cs_n` rises on the same edge as the last falling edge of `sclk`.
- R5: Data is captured only on rising `sclk` edges numbered `CAP_IDX` and above, counting from 1 after the fall of `cs_n`. `CAP_IDX` is `FIRST_IDX`, raised to `ACQ_FALLS + 1` if needed, so that no bit is taken before the `ACQ_FALLS`-th falling edge.
- R6: Bit `DATA_W-1` of `result` is the `sdo` value at rising edge `CAP_IDX`. Each later rising edge supplies the next lower bit.
- R7: The level on `sdo` while `cs_n` is 1, or at rising edges outside the capture range, does not affect `result`.
- R8: After a frame, `cs_n` stays high for exactly `GAP_CLKS` system clocks before `valid`. A new frame never starts after fewer than `GAP_CLKS` high cycles.
- R9: `valid` is high for exactly one cycle, `busy` is 0 in that cycle, and `result` holds the new sample.
- R10: A `start` pulse while `busy` is 1 is ignored: exactly one `valid` follows, and no second frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request one conversion frame |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | High from frame start until the result is delivered |
| valid | output | 1 | One-cycle strobe marking a new result |
| result | output | DATA_W | Assembled sample, MSB first |

## Verification
If the pulse index is wrong, the frame has the wrong number of `sclk` pulses, and the sample is shifted by whole bits. This appears at `result` on the very next `valid`. The bench feeds alternating filler bits outside the capture window, so an early or late capture edge shows up as a corrupted sample in that same frame. A mistake in the divider or the tail counter shows up as a wrong phase length or a wrong chip-select high time within one half period, or within `GAP_CLKS` cycles.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_TAIL = 2'd2
  } rd_state_t;
endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int HALF_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CNT_W = $clog2(HALF_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  assign tick = run && (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;
endmodule

// File: rtl/msb_shifter.sv
module msb_shifter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (en) word_d = {word_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int HALF_CYC  = 14,
  parameter int ACQ_FALLS = 6,
  parameter int GAP_CLKS  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic valid,
  input logic cap_en
);
  localparam int HL_W = $clog2(HALF_CYC + 2);
  localparam int FC_W = $clog2(ACQ_FALLS + 2);
  localparam int GC_W = $clog2(GAP_CLKS + 2);
  localparam logic [HL_W-1:0] HL_MAX = HL_W'(HALF_CYC + 1);
  localparam logic [FC_W-1:0] FC_MAX = FC_W'(ACQ_FALLS + 1);
  localparam logic [GC_W-1:0] GC_MAX = GC_W'(GAP_CLKS);

  logic [HL_W-1:0] hi_len;
  logic [FC_W-1:0] fall_cnt;
  logic [GC_W-1:0] cs_hi_cnt;
  logic            sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len    <= '0;
      fall_cnt  <= '0;
      cs_hi_cnt <= GC_MAX;
      sclk_q    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (!sclk)              hi_len <= '0;
      else if (hi_len < HL_MAX) hi_len <= hi_len + 1'b1;
      if (cs_n)                              fall_cnt <= '0;
      else if (sclk_q && !sclk && fall_cnt < FC_MAX) fall_cnt <= fall_cnt + 1'b1;
      if (!cs_n)                  cs_hi_cnt <= '0;
      else if (cs_hi_cnt < GC_MAX) cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk && !valid || valid && cs_n && !sclk));

  a_r3_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r3_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_len == HL_W'(HALF_CYC));

  a_r5_no_early_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (!cs_n && fall_cnt >= FC_W'(ACQ_FALLS)));

  a_r8_min_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> cs_hi_cnt >= GC_MAX);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r9_not_busy_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(
  .HALF_CYC (HALF_CYC),
  .ACQ_FALLS(ACQ_FALLS),
  .GAP_CLKS (GAP_CLKS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n),
  .sclk  (sclk),
  .busy  (busy),
  .valid (valid),
  .cap_en(cap_en)
);

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int HALF_CYC  = 14,
  parameter int ACQ_FALLS = 6,
  parameter int FIRST_IDX = 8,
  parameter int GAP_CLKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sdo,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] result
);
  localparam int CAP_IDX  = (FIRST_IDX > ACQ_FALLS) ? FIRST_IDX : ACQ_FALLS + 1;
  localparam int LAST_IDX = CAP_IDX + DATA_W - 1;
  localparam int RISE_W   = $clog2(LAST_IDX + 1);
  localparam int GAP_W    = $clog2(GAP_CLKS + 1);
  localparam logic [RISE_W-1:0] CAP_V  = RISE_W'(CAP_IDX);
  localparam logic [RISE_W-1:0] LAST_V = RISE_W'(LAST_IDX);
  localparam logic [GAP_W-1:0]  GAP_V  = GAP_W'(GAP_CLKS - 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  rd_state_t         state_q, state_d;
  logic [RISE_W-1:0] n_rise_q, n_rise_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              cs_n_q, cs_n_d;
  logic              valid_q, valid_d;
  logic              run, rise, fall, cap_en;
  logic [RISE_W-1:0] rise_idx;

  assign run      = (state_q == ST_CONV);
  assign rise_idx = n_rise_q + 1'b1;
  assign cap_en   = rise && (rise_idx >= CAP_V) && (rise_idx <= LAST_V);

  sclk_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk  (clk),
    .rst_n(rst_core_n),
    .run  (run),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  msb_shifter #(.W(DATA_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_core_n),
    .en   (cap_en),
    .din  (sdo),
    .word (result)
  );

  always_comb begin
    state_d  = state_q;
    n_rise_d = n_rise_q;
    gap_d    = gap_q;
    cs_n_d   = cs_n_q;
    valid_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_CONV;
          cs_n_d   = 1'b0;
          n_rise_d = '0;
        end
      end
      ST_CONV: begin
        if (rise) n_rise_d = rise_idx;
        if (fall && n_rise_q == LAST_V) begin
          state_d = ST_TAIL;
          cs_n_d  = 1'b1;
          gap_d   = '0;
        end
      end
      ST_TAIL: begin
        if (gap_q == GAP_V) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cs_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q  <= ST_IDLE;
      n_rise_q <= '0;
      gap_q    <= '0;
      cs_n_q   <= 1'b1;
      valid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      n_rise_q <= n_rise_d;
      gap_q    <= gap_d;
      cs_n_q   <= cs_n_d;
      valid_q  <= valid_d;
    end
  end

  assign cs_n  = cs_n_q;
  assign busy  = (state_q != ST_IDLE);
  assign valid = valid_q;
endmodule

// File: tb/adc_frame_ctrl_tb.sv
module adc_frame_ctrl_tb;
  localparam int DW   = 14;
  localparam int HALF = 3;
  localparam int GAP  = 5;
  localparam int CAP  = 8;
  localparam int LAST = CAP + DW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdo = 1'b0;
  logic cs_n, sclk, busy, valid;
  logic [DW-1:0] result;

  always #4 clk = ~clk;

  adc_frame_ctrl #(
    .DATA_W(DW), .HALF_CYC(HALF), .ACQ_FALLS(6), .FIRST_IDX(CAP), .GAP_CLKS(GAP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .valid(valid), .result(result)
  );

  int n_chk = 0, n_bad = 0;
  int rises = 0, frame_rises = 0, cs_hi = 0, gap_at_fall = 0, hi_at_valid = 0;
  int valid_cnt = 0, phase_bad = 0, run_len = 0, falls = 0, cyc = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1, busy_at_valid = 1'b0;
  logic [DW-1:0] smp = '0, got = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic model_bit(input int k);
    if (k >= CAP && k <= LAST) return smp[DW-1-(k-CAP)];
    return k[0];
  endfunction

  // converter model and port monitor, all on the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (cs_n) begin
      if (!prev_cs) frame_rises = rises;
      cs_hi++;
      if (sclk) phase_bad++;
      rises = 0;
      sdo = cyc[0];
    end else begin
      if (prev_cs) begin
        gap_at_fall = cs_hi;
        cs_hi = 0;
        falls++;
        run_len = 1;
      end else if (sclk != prev_sclk) begin
        if (run_len != HALF) phase_bad++;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (sclk && !prev_sclk) rises++;
      sdo = model_bit(rises + 1);
    end
    if (valid) begin
      valid_cnt++;
      got = result;
      hi_at_valid = cs_hi;
      busy_at_valid = busy;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_frame(input logic [DW-1:0] v, input bit poke);
    int t;
    smp = v;
    valid_cnt = 0;
    phase_bad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cs_n == 1'b0 && busy == 1'b1, "R2 cs_n/busy after start", {cs_n, busy}, 1);
    @(negedge clk);
    chk(gap_at_fall >= GAP, "R8 deselect time before frame", gap_at_fall, GAP);
    t = 0;
    while (valid_cnt == 0 && t < 2000) begin
      @(negedge clk);
      t++;
      start = (poke && rises == 10);
    end
    start = 1'b0;
    chk(got == v, "R5 R6 R7 sample", got, v);
    chk(frame_rises == LAST, "R4 pulse count", frame_rises, LAST);
    chk(phase_bad == 0, "R3 phase length", phase_bad, 0);
    chk(hi_at_valid == GAP + 1, "R8 tail length", hi_at_valid, GAP + 1);
    chk(busy_at_valid == 1'b0, "R9 busy at strobe", busy_at_valid, 0);
    @(negedge clk); @(negedge clk);
    chk(valid_cnt == 1 && !valid, "R9 single strobe", valid_cnt, 1);
    if (poke) begin
      int f0;
      f0 = falls;
      repeat (3 * GAP) @(negedge clk);
      chk(falls == f0 && cs_n && !busy, "R10 start while busy", falls - f0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !valid, "R1 in reset", {cs_n, sclk, busy, valid}, 8);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(cs_n && !sclk && !busy && !valid, "R1 idle", {cs_n, sclk, busy, valid}, 8);

    run_frame(14'h0000, 1'b0);
    run_frame(14'h3FFF, 1'b0);
    run_frame(14'h2AAA, 1'b0);
    run_frame(14'h1555, 1'b0);
    for (int i = 0; i < DW; i++) run_frame(14'(1 << i), 1'b0);
    for (int i = 0; i < DW; i++) run_frame(~14'(1 << i), 1'b0);
    for (int i = 0; i < 24; i++) run_frame(14'((i * 4793 + 77) & 16'h3FFF), 1'b0);
    run_frame(14'h2D3C, 1'b1);
    run_frame(14'h0F0F, 1'b1);

    // reset in the middle of a frame
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !valid, "R1 reset mid-frame", {cs_n, sclk, busy, valid}, 8);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    run_frame(14'h3A5C, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule